// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns read and write commands for a synchronous graphics memory into a stream of column addresses, one per clock. A command carries a starting column and a bank. The block then walks the columns of that row in the order set by the programmed burst length and burst type. It marks the final beat of each burst. A second strobe repeats every read beat after the programmed CAS latency, so the data path can capture read data in the cycle it arrives.

A mode register holds four settings: the burst length code, the ordering (sequential or interleaved), the CAS latency (2 or 3) and a single-write option. With the single-write option set, writes go out as one beat while reads keep the programmed length. The mode register accepts a load only while the block is idle. A terminate input cuts any burst short and is the only way to end a full-page burst. Each row holds 2^COL_W columns, which is 8 by default. Both banks use the same sequencing, so the bank tag travels alongside the address unchanged.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_vld`, `col_last` and `rd_vld` are 0. The mode register holds burst code 0 (one beat), sequential order, CAS latency 2 and single-write off.
- R2: A command sampled at a clock edge produces a beat in the very next cycle: `col_vld`=1, `col_addr`=start column, and `col_bank`=command bank. `col_wr` is 1 for a write. After that, one beat is issued per clock.
- R3: With sequential order and `mode_bl` codes 0, 1, 2 and 3, the burst length L is 1, 2, 4 and 8. Beat n carries the start column with its low log2(L) bits replaced by (start + n) mod L, so the burst wraps inside the aligned block of L columns.
- R4: With interleaved order (`mode_ilv`=1) and a fixed length, beat n carries the start column with its low log2(L) bits XORed with n.
- R5: `col_last` is 1 on beat L-1 of a fixed-length burst and only there. Unless a new command arrives, `col_vld` is 0 in the cycle after the last beat.
- R6: `mode_bl` codes 4 to 7 select full page. Beat n is (start + n) mod 2^COL_W, always in sequential order. The burst wraps across the whole row, continues without limit and never raises `col_last`.
- R7: A `term` sampled during a burst with no command at the same edge removes the beat from the next cycle. A `term` sampled while idle has no effect.
- R8: A read beat visible in cycle t raises `rd_vld` in cycle t+2 when `mode_cl3`=0 and in cycle t+3 when `mode_cl3`=1. Write beats never raise `rd_vld`.
- R9: With `mode_wsingle`=1, a write command yields one beat that has `col_last`=1, while read commands keep the programmed length.
- R10: A command arriving during a burst aborts that burst, and the new sequence starts in the next cycle. If `rd_cmd` and `wr_cmd` are both 1, the command is a read.
- R11: `mode_ld` is ignored while a beat is visible or a read beat is still waiting to raise `rd_vld`. An accepted load applies to commands sampled after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ld | input | 1 | Load the mode fields below |
| mode_bl | input | 3 | Burst length code: 0..3 give 1,2,4,8 beats; 4..7 give full page |
| mode_ilv | input | 1 | 1 selects interleaved order |
| mode_cl3 | input | 1 | 0 selects CAS latency 2, 1 selects latency 3 |
| mode_wsingle | input | 1 | 1 limits writes to a single beat |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| cmd_bank | input | BANK_W | Bank of the command |
| start_col | input | COL_W | Starting column of the command |
| term | input | 1 | Terminate the running burst |
| col_addr | output | COL_W | Column address of the current beat |
| col_bank | output | BANK_W | Bank of the current beat |
| col_vld | output | 1 | A beat is present |
| col_last | output | 1 | Current beat is the final one of the burst |
| col_wr | output | 1 | Current beat belongs to a write |
| rd_vld | output | 1 | Read data is due this cycle |

## Verification
The hardest state to reach is a mode load that collides with an empty address stream while read beats are still draining through the latency pipeline. It matters most when the CAS latency itself is being changed, because a wrong acceptance would misalign `rd_vld` on the next burst. Random stimulus produces mode loads often, including in the two or three cycles after a read ends. A directed case loads a new length one cycle after a single-beat read at latency 3, then counts the beats of the next read. Full-page wrapping across the row end and termination after many wraps are also driven directly.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Programmed operating mode
    typedef struct packed {
        logic [2:0] bl_code;   // 0..3 -> 1,2,4,8 beats; 4..7 -> full page
        logic       ilv;       // interleaved ordering
        logic       cl3;       // CAS latency 3 when set, else 2
        logic       wsingle;   // writes limited to one beat
    } mode_t;

    localparam mode_t MODE_RESET = '{bl_code: 3'd0, ilv: 1'b0, cl3: 1'b0, wsingle: 1'b0};

    localparam int unsigned MAX_CL = 3;

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_i,
    input  logic  busy_i,
    input  mode_t mode_i,
    output mode_t mode_o
);

    typedef struct packed {
        mode_t mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i && !busy_i) begin
            st_d.mode = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R11: a load while busy leaves the register untouched
    p_ld_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && busy_i) |=> $stable(st_q.mode));

    // R11: an idle load is taken
    p_ld_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !busy_i) |=> (st_q.mode == $past(mode_i)));

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 3,
    parameter int unsigned BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode_i,
    input  logic              rd_cmd_i,
    input  logic              wr_cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  start_i,
    input  logic              term_i,
    output logic [COL_W-1:0]  addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              vld_o,
    output logic              last_o,
    output logic              wr_o
);

    localparam logic [COL_W-1:0] ROW_MASK = {COL_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic              last;
        logic              wr;
        logic              full;
        logic              ilv;
        logic [COL_W-1:0]  mask;
        logic [COL_W-1:0]  beat;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  addr;
        logic [BANK_W-1:0] bank;
    } st_t;

    st_t st_d, st_q;

    logic              cmd;
    logic              is_wr;
    logic              one_beat_wr;
    logic              cmd_full;
    logic [COL_W-1:0]  cmd_mask;
    logic [COL_W-1:0]  nb;
    logic [COL_W-1:0]  off;
    logic [COL_W-1:0]  nxt_addr;

    // Low-bit mask for a fixed burst length code
    function automatic logic [COL_W-1:0] len_mask(input logic [1:0] code);
        return COL_W'((32'd1 << code) - 32'd1);
    endfunction

    always_comb begin
        cmd         = rd_cmd_i || wr_cmd_i;
        is_wr       = wr_cmd_i && !rd_cmd_i;
        one_beat_wr = is_wr && mode_i.wsingle;
        cmd_full    = mode_i.bl_code[2] && !one_beat_wr;
        if (one_beat_wr) begin
            cmd_mask = '0;
        end else if (mode_i.bl_code[2]) begin
            cmd_mask = ROW_MASK;
        end else begin
            cmd_mask = len_mask(mode_i.bl_code[1:0]);
        end

        nb       = st_q.beat + 1'b1;
        off      = st_q.ilv ? (st_q.start ^ nb) : (st_q.start + nb);
        nxt_addr = (st_q.start & ~st_q.mask) | (off & st_q.mask);

        st_d = st_q;
        if (cmd) begin
            st_d.vld   = 1'b1;
            st_d.wr    = is_wr;
            st_d.full  = cmd_full;
            st_d.ilv   = mode_i.ilv && !cmd_full;
            st_d.mask  = cmd_mask;
            st_d.beat  = '0;
            st_d.start = start_i;
            st_d.addr  = start_i;
            st_d.bank  = bank_i;
            st_d.last  = !cmd_full && (cmd_mask == '0);
        end else if (st_q.vld && (term_i || st_q.last)) begin
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
        end else if (st_q.vld) begin
            st_d.beat = nb;
            st_d.addr = nxt_addr;
            st_d.last = !st_q.full && (nb == st_q.mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign bank_o = st_q.bank;
    assign vld_o  = st_q.vld;
    assign last_o = st_q.last;
    assign wr_o   = st_q.wr;

    // R2 / R10: a command always yields its start column in the next cycle
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_i || wr_cmd_i) |=> (vld_o && addr_o == $past(start_i) && bank_o == $past(bank_i)));

    // R10: read wins when both strobes are present
    p_rd_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_i && wr_cmd_i) |=> !wr_o);

    // R5: no beat after the last one unless a command restarts
    p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && last_o && !rd_cmd_i && !wr_cmd_i) |=> !vld_o);

    // R6: a full-page burst never flags a last beat
    p_full_never_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && st_q.full) |-> !last_o);

    // R7: terminate removes the next beat
    p_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && term_i && !rd_cmd_i && !wr_cmd_i) |=> !vld_o);

    // R9: single-write mode gives a one-beat write
    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_i && !rd_cmd_i && mode_i.wsingle) |=> (vld_o && wr_o && last_o));

    // R3: sequential beats step by one inside the aligned block
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !st_q.ilv && !last_o && !term_i && !rd_cmd_i && !wr_cmd_i)
        |=> (vld_o && ((addr_o & st_q.mask) == (($past(addr_o) + 1'b1) & st_q.mask))));

endmodule

// File: rtl/bcs_rd_pipe.sv
module bcs_rd_pipe
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_i,
    input  logic cl3_i,
    output logic rd_vld_o,
    output logic busy_o
);

    typedef struct packed {
        logic [MAX_CL-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[MAX_CL-2:0], beat_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld_o = cl3_i ? st_q.sh[MAX_CL-1] : st_q.sh[MAX_CL-2];
    assign busy_o   = |st_q.sh;

    // R8: latency 2 alignment
    p_cl2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && !cl3_i) |-> $past(beat_i, 2));

    // R8: latency 3 alignment
    p_cl3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && cl3_i) |-> $past(beat_i, 3));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 3,
    parameter int unsigned BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [2:0]        mode_bl,
    input  logic              mode_ilv,
    input  logic              mode_cl3,
    input  logic              mode_wsingle,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic              term,
    output logic [COL_W-1:0]  col_addr,
    output logic [BANK_W-1:0] col_bank,
    output logic              col_vld,
    output logic              col_last,
    output logic              col_wr,
    output logic              rd_vld
);

    mode_t mode_in;
    mode_t mode_cur;
    logic  pipe_busy;
    logic  busy;
    logic  rd_beat;

    assign mode_in = '{bl_code: mode_bl, ilv: mode_ilv, cl3: mode_cl3, wsingle: mode_wsingle};
    assign busy    = col_vld || pipe_busy;
    assign rd_beat = col_vld && !col_wr;

    bcs_mode_reg i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (mode_ld),
        .busy_i (busy),
        .mode_i (mode_in),
        .mode_o (mode_cur)
    );

    bcs_addr_gen #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_cur),
        .rd_cmd_i (rd_cmd),
        .wr_cmd_i (wr_cmd),
        .bank_i   (cmd_bank),
        .start_i  (start_col),
        .term_i   (term),
        .addr_o   (col_addr),
        .bank_o   (col_bank),
        .vld_o    (col_vld),
        .last_o   (col_last),
        .wr_o     (col_wr)
    );

    bcs_rd_pipe i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_i   (rd_beat),
        .cl3_i    (mode_cur.cl3),
        .rd_vld_o (rd_vld),
        .busy_o   (pipe_busy)
    );

    // R1: quiet outputs right after reset release
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!col_vld && !rd_vld));

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

    localparam int COL_W  = 3;
    localparam int BANK_W = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ld = 0, mode_ilv = 0, mode_cl3 = 0, mode_wsingle = 0;
    logic [2:0] mode_bl = 0;
    logic rd_cmd = 0, wr_cmd = 0, term = 0;
    logic [BANK_W-1:0] cmd_bank = 0;
    logic [COL_W-1:0] start_col = 0;
    logic [COL_W-1:0] col_addr;
    logic [BANK_W-1:0] col_bank;
    logic col_vld, col_last, col_wr, rd_vld;

    always #4 clk = ~clk;   // 125 MHz

    burst_col_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_bl(mode_bl),
        .mode_ilv(mode_ilv), .mode_cl3(mode_cl3), .mode_wsingle(mode_wsingle),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .cmd_bank(cmd_bank), .start_col(start_col),
        .term(term), .col_addr(col_addr), .col_bank(col_bank), .col_vld(col_vld),
        .col_last(col_last), .col_wr(col_wr), .rd_vld(rd_vld)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    logic [2:0] m_bl; logic m_ilvm, m_cl3, m_ws;
    logic m_vld, m_last, m_wr, m_full, m_ilv;
    logic [COL_W-1:0] m_mask, m_beat, m_start, m_addr;
    logic [BANK_W-1:0] m_bank;
    logic [2:0] m_pipe;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [COL_W-1:0] beat_addr(input logic [COL_W-1:0] s,
            input logic [COL_W-1:0] n, input logic [COL_W-1:0] mk, input logic ilv);
        logic [COL_W-1:0] o;
        o = ilv ? (s ^ n) : (s + n);
        return (s & ~mk) | (o & mk);
    endfunction

    task automatic model_reset();
        m_bl = 0; m_ilvm = 0; m_cl3 = 0; m_ws = 0;
        m_vld = 0; m_last = 0; m_wr = 0; m_full = 0; m_ilv = 0;
        m_mask = 0; m_beat = 0; m_start = 0; m_addr = 0; m_bank = 0; m_pipe = 0;
    endtask

    task automatic tick();
        logic busy;
        logic wr;
        busy = m_vld | (|m_pipe);
        m_pipe = {m_pipe[1:0], m_vld & ~m_wr};
        if (rd_cmd || wr_cmd) begin
            wr = !rd_cmd;
            m_full = m_bl[2];
            m_mask = m_bl[2] ? 3'd7 : COL_W'((1 << m_bl[1:0]) - 1);
            if (wr && m_ws) begin m_mask = 0; m_full = 0; end
            m_ilv = m_ilvm && !m_full;
            m_start = start_col; m_beat = 0; m_addr = start_col;
            m_vld = 1; m_wr = wr; m_bank = cmd_bank;
            m_last = !m_full && (m_mask == 0);
        end else if (m_vld && (term || m_last)) begin
            m_vld = 0; m_last = 0;
        end else if (m_vld) begin
            m_beat = m_beat + 1'b1;
            m_addr = beat_addr(m_start, m_beat, m_mask, m_ilv);
            m_last = !m_full && (m_beat == m_mask);
        end
        if (mode_ld && !busy) begin
            m_bl = mode_bl; m_ilvm = mode_ilv; m_cl3 = mode_cl3; m_ws = mode_wsingle;
        end
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check("R2 vld", col_vld, m_vld);
        if (m_vld) begin
            check(m_full ? "R6 addr" : (m_ilv ? "R4 addr" : "R3 addr"), col_addr, m_addr);
            check("R5 last", col_last, m_last);
            check("R2 wr", col_wr, m_wr);
            check("R2 bank", col_bank, m_bank);
        end
        check("R8 rd_vld", rd_vld, m_cl3 ? m_pipe[2] : m_pipe[1]);
    endtask

    task automatic idle_inputs();
        rd_cmd = 0; wr_cmd = 0; term = 0; mode_ld = 0;
    endtask

    task automatic load_mode(input logic [2:0] bl, input logic ilv, input logic cl3, input logic ws);
        idle_inputs();
        mode_ld = 1; mode_bl = bl; mode_ilv = ilv; mode_cl3 = cl3; mode_wsingle = ws;
        tick();
        mode_ld = 0;
    endtask

    task automatic drain();
        idle_inputs();
        for (int i = 0; i < 12; i++) tick();
    endtask

    // Issue one command then count beats until the stream goes quiet
    task automatic run_count(input logic rd, input logic [COL_W-1:0] s, output int beats);
        idle_inputs();
        rd_cmd = rd; wr_cmd = !rd; start_col = s;
        tick();
        idle_inputs();
        beats = 0;
        for (int i = 0; i < 20; i++) begin
            if (col_vld) beats++;
            tick();
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        int n;
        void'($urandom(32'd20251));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 col_vld", col_vld, 0);
        check("R1 col_last", col_last, 0);
        check("R1 rd_vld", rd_vld, 0);
        // R1: default mode is one beat, sequential
        run_count(1, 3'd5, n);
        check("R1 default length", n, 1);

        // R7: terminate while idle does nothing
        idle_inputs(); term = 1; tick(); term = 0;
        check("R7 idle term", col_vld, 0);

        // R3: sequential BL4 from column 6 wraps to 4
        load_mode(3'd2, 0, 0, 0);
        idle_inputs(); rd_cmd = 1; start_col = 3'd6; tick(); idle_inputs();
        check("R3 first", col_addr, 6);
        tick(); check("R3 wrap", col_addr, 7);
        tick(); check("R3 wrap2", col_addr, 4);
        drain();

        // R4: interleaved BL8 from column 5, beat 2 is 7
        load_mode(3'd3, 1, 1, 0);
        idle_inputs(); rd_cmd = 1; start_col = 3'd5; tick(); idle_inputs();
        tick(); check("R4 beat1", col_addr, 4);
        tick(); check("R4 beat2", col_addr, 7);
        drain();

        // R11: load during a read is ignored
        load_mode(3'd2, 0, 1, 0);
        idle_inputs(); rd_cmd = 1; start_col = 0; tick(); idle_inputs();
        load_mode(3'd0, 0, 0, 0);
        drain();
        run_count(1, 3'd0, n);
        check("R11 ignored load keeps length", n, 4);
        // R11: load while only the latency pipe is busy (CL3)
        load_mode(3'd0, 0, 1, 0);
        run_count(1, 3'd1, n);
        idle_inputs(); rd_cmd = 1; start_col = 0; tick(); idle_inputs();
        tick();
        load_mode(3'd3, 0, 0, 0);
        drain();
        run_count(1, 3'd0, n);
        check("R11 pipe-busy load ignored", n, 1);

        // R6 / R7: full page wraps and ends only on term
        load_mode(3'd7, 1, 0, 0);
        idle_inputs(); rd_cmd = 1; start_col = 3'd5; tick(); idle_inputs();
        for (int i = 0; i < 19; i++) tick();
        check("R6 still running", col_vld, 1);
        check("R6 wrapped addr", col_addr, 3'((5 + 19) % 8));
        term = 1; tick(); term = 0;
        check("R7 term stops", col_vld, 0);
        drain();

        // R9: single write mode
        load_mode(3'd2, 0, 0, 1);
        run_count(0, 3'd2, n);
        check("R9 write one beat", n, 1);
        run_count(1, 3'd2, n);
        check("R9 read keeps length", n, 4);

        // R10: abort and priority
        idle_inputs(); wr_cmd = 1; start_col = 3'd1; tick();
        wr_cmd = 0; rd_cmd = 1; start_col = 3'd6; tick(); idle_inputs();
        check("R10 restart addr", col_addr, 6);
        idle_inputs(); rd_cmd = 1; wr_cmd = 1; start_col = 3'd3; tick(); idle_inputs();
        check("R10 read priority", col_wr, 0);
        drain();

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            idle_inputs();
            rd_cmd = (r < 10);
            wr_cmd = (r >= 8 && r < 16);
            term = ($urandom_range(0, 9) == 0);
            mode_ld = ($urandom_range(0, 11) == 0);
            mode_bl = 3'($urandom_range(0, 7));
            mode_ilv = 1'($urandom_range(0, 1));
            mode_cl3 = 1'($urandom_range(0, 1));
            mode_wsingle = 1'($urandom_range(0, 1));
            start_col = COL_W'($urandom);
            cmd_bank = BANK_W'($urandom);
            tick();
        end
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule